// File: doc/BRIEF.md
# Inductor Switching Path Sequencer

This block sequences the power switches of a converter that shares one inductor between a step-down (buck) output and a step-up (boost) output. Each switching cycle is started by a rising edge on a slow cycle strobe. The sequencer then walks the inductor through four current paths in a fixed order: delivery to the buck output, fast charge of the inductor from the supply, delivery to the boost output, and freewheel. Every phase after the first is entered when an analog comparator flag belonging to the current phase falls. Freewheel holds until the next cycle strobe.

A mode input selects hysteresis operation for the buck output. In that mode the inductor is not charged. The buck switch and the freewheel switch are closed together so that the supply feeds the buck output directly. This happens while a hysteresis comparator reports the output below its lower threshold, and the pair opens when the comparator reports it above the upper one. All four gate enables pass through a non-overlap stage. This stage keeps every enable low for a parameterised number of fast clock cycles before a different one rises.

Top module: `sido_path_seq`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first cycle strobe rise, all four enables are low. Flag falls in that idle state have no effect.
- R2: With hysteresis mode off, a rising edge of `cycle_i` starts the buck phase. When the outputs are idle with no gap pending, `buck_en_o` is high on the second rising clock edge after the input is sampled.
- R3: In the buck phase, a high-to-low transition of `buck_done_i` moves the sequencer to the fast-charge phase (`charge_en_o`).
- R4: In the fast-charge phase, a high-to-low transition of `peak_i` moves the sequencer to the boost-delivery phase (`boost_en_o`).
- R5: In the boost phase, a high-to-low transition of `boost_done_i` moves the sequencer to freewheel (`fw_en_o`). Freewheel is held until the next cycle strobe rise.
- R6: A falling flag that does not belong to the current phase is ignored, as are rising edges of any flag.
- R7: A cycle strobe rise that arrives before freewheel is reached restarts the sequence at the buck phase. If the buck phase is already active, it stays active with no gap.
- R8: At any time at most one enable is high. The only exception is the hysteresis bypass pair, encoded {buck,charge,boost,fw} = 1001.
- R9: When the active drive changes, all enables are low for exactly `DEAD_CYC` clock cycles before the new enable rises. An enable never changes directly into another.
- R10: With `hyst_mode_i` high, charge and boost are never driven. The bypass pair is driven while `hyst_low_i` is high and released while it is low. Phase flags and the cycle strobe are ignored.
- R11: When `hyst_mode_i` falls, all enables go low and the sequencer idles. The next cycle strobe rise starts the buck phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cycle_i | input | 1 | Switching cycle strobe; rising edge starts a cycle |
| buck_done_i | input | 1 | Buck charge delivered comparator; falls when done |
| peak_i | input | 1 | Peak current comparator; falls when target passed |
| boost_done_i | input | 1 | Boost charge delivered comparator; falls when done |
| hyst_mode_i | input | 1 | High selects hysteresis mode for the buck output |
| hyst_low_i | input | 1 | Buck hysteresis comparator; high below lower threshold |
| buck_en_o | output | 1 | Buck delivery switch enable |
| charge_en_o | output | 1 | Fast charge switch enable |
| boost_en_o | output | 1 | Boost delivery switch enable |
| fw_en_o | output | 1 | Freewheel switch enable |

## Verification
The bench builds the block with `DEAD_CYC` = 3. With that value a phase change lands on a predictable clock: all enables are low on the fourth sample after the flag fall and the new enable is high on the fifth, so the length of the gap is pinned exactly. A short gap also lets the bench restart the sequence from each of the buck, charge and boost phases in turn. In each phase it fires every flag that does not belong there. It also enters and leaves hysteresis mode while stray strobes and flags arrive.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_BUCK, PH_CHARGE, PH_BOOST, PH_FREE, PH_HYST
  } phase_e;

  typedef enum logic [2:0] {
    DRV_NONE, DRV_BUCK, DRV_CHARGE, DRV_BOOST, DRV_FREE, DRV_BYPASS
  } drive_e;

  localparam int unsigned NUM_SW    = 4;
  localparam int unsigned SW_FREE   = 0;
  localparam int unsigned SW_BOOST  = 1;
  localparam int unsigned SW_CHARGE = 2;
  localparam int unsigned SW_BUCK   = 3;

  localparam int unsigned NUM_FLAGS  = 3;
  localparam int unsigned FLAG_BUCK  = 0;
  localparam int unsigned FLAG_PEAK  = 1;
  localparam int unsigned FLAG_BOOST = 2;

  function automatic logic [NUM_SW-1:0] drive_to_en(input drive_e d);
    logic [NUM_SW-1:0] en;
    en = '0;
    case (d)
      DRV_BUCK:   en[SW_BUCK]   = 1'b1;
      DRV_CHARGE: en[SW_CHARGE] = 1'b1;
      DRV_BOOST:  en[SW_BOOST]  = 1'b1;
      DRV_FREE:   en[SW_FREE]   = 1'b1;
      DRV_BYPASS: begin
        en[SW_BUCK] = 1'b1;
        en[SW_FREE] = 1'b1;
      end
      default:    en = '0;
    endcase
    return en;
  endfunction

endpackage

// File: rtl/sps_edge_det.sv
module sps_edge_det #(
  parameter int unsigned W       = 1,
  parameter bit          FALLING = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] edge_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q & ~sig_i;
    end else begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/sps_phase_fsm.sv
module sps_phase_fsm
  import sps_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cyc_start_i,
  input  logic [NUM_FLAGS-1:0] done_i,
  input  logic                 hyst_mode_i,
  input  logic                 hyst_low_i,
  output drive_e               req_o
);

  phase_e state_q, state_d;
  logic   byp_q, byp_d;

  always_comb begin
    state_d = state_q;
    byp_d   = 1'b0;
    if (hyst_mode_i) begin
      state_d = PH_HYST;
      byp_d   = hyst_low_i;
    end else if (state_q == PH_HYST) begin
      state_d = PH_IDLE;
    end else if (cyc_start_i) begin
      // restart wins over any pending phase flag
      state_d = PH_BUCK;
    end else begin
      case (state_q)
        PH_BUCK:   if (done_i[FLAG_BUCK])  state_d = PH_CHARGE;
        PH_CHARGE: if (done_i[FLAG_PEAK])  state_d = PH_BOOST;
        PH_BOOST:  if (done_i[FLAG_BOOST]) state_d = PH_FREE;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byp_q   <= byp_d;
    end
  end

  always_comb begin
    case (state_q)
      PH_BUCK:   req_o = DRV_BUCK;
      PH_CHARGE: req_o = DRV_CHARGE;
      PH_BOOST:  req_o = DRV_BOOST;
      PH_FREE:   req_o = DRV_FREE;
      PH_HYST:   req_o = byp_q ? DRV_BYPASS : DRV_NONE;
      default:   req_o = DRV_NONE;
    endcase
  end

endmodule

// File: rtl/sps_deadtime.sv
module sps_deadtime
  import sps_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  drive_e req_i,
  output drive_e cur_o
);

  localparam int unsigned CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

  drive_e        cur_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= DRV_NONE;
      cnt_q <= '0;
    end else if (req_i != cur_q) begin
      if (cur_q != DRV_NONE) begin
        // drop everything first, then count the gap
        cur_q <= DRV_NONE;
        cnt_q <= RELOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cur_q <= req_i;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/sido_path_seq.sv
module sido_path_seq
  import sps_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_i,
  input  logic buck_done_i,
  input  logic peak_i,
  input  logic boost_done_i,
  input  logic hyst_mode_i,
  input  logic hyst_low_i,
  output logic buck_en_o,
  output logic charge_en_o,
  output logic boost_en_o,
  output logic fw_en_o
);

  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] flag_fall;
  logic                 cyc_rise;
  drive_e               req, cur;
  logic [NUM_SW-1:0]    en;

  always_comb begin
    flags             = '0;
    flags[FLAG_BUCK]  = buck_done_i;
    flags[FLAG_PEAK]  = peak_i;
    flags[FLAG_BOOST] = boost_done_i;
  end

  sps_edge_det #(.W(1), .FALLING(1'b0)) u_cyc_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (cycle_i),
    .edge_o (cyc_rise)
  );

  sps_edge_det #(.W(NUM_FLAGS), .FALLING(1'b1)) u_flag_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (flags),
    .edge_o (flag_fall)
  );

  sps_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_start_i (cyc_rise),
    .done_i      (flag_fall),
    .hyst_mode_i (hyst_mode_i),
    .hyst_low_i  (hyst_low_i),
    .req_o       (req)
  );

  sps_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .cur_o  (cur)
  );

  assign en          = drive_to_en(cur);
  assign buck_en_o   = en[SW_BUCK];
  assign charge_en_o = en[SW_CHARGE];
  assign boost_en_o  = en[SW_BOOST];
  assign fw_en_o     = en[SW_FREE];

endmodule

// File: rtl/sido_path_seq_chk.sv
module sido_path_seq_chk #(
  parameter int unsigned DEAD_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hyst_mode_i,
  input logic buck_en_o,
  input logic charge_en_o,
  input logic boost_en_o,
  input logic fw_en_o
);

  localparam int unsigned LW = $clog2(DEAD_CYC + 1);

  logic [3:0]    en;
  logic [LW-1:0] low_cnt_q;
  logic          seen_q;

  assign en = {buck_en_o, charge_en_o, boost_en_o, fw_en_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      seen_q    <= 1'b0;
    end else if (en != 4'b0000) begin
      low_cnt_q <= '0;
      seen_q    <= 1'b1;
    end else if (low_cnt_q < LW'(DEAD_CYC)) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == 4'b0000) || $onehot(en) || (en == 4'b1001)); // R8

  AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(en) == 4'b0000 && en != 4'b0000) |-> (low_cnt_q >= LW'(DEAD_CYC))); // R9

  AST_NO_DIRECT_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en) != 4'b0000 && en != 4'b0000) |-> (en == $past(en))); // R9

  AST_HYST_NO_INDUCTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hyst_mode_i && $past(hyst_mode_i) && $past(hyst_mode_i, 2)) |-> (!charge_en_o && !boost_en_o)); // R10

  AST_BYPASS_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == 4'b1001) |-> $past(hyst_mode_i, 2)); // R10

endmodule

bind sido_path_seq sido_path_seq_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hyst_mode_i (hyst_mode_i),
  .buck_en_o   (buck_en_o),
  .charge_en_o (charge_en_o),
  .boost_en_o  (boost_en_o),
  .fw_en_o     (fw_en_o)
);

// File: tb/sido_path_seq_tb.sv
module sido_path_seq_tb;

  localparam int unsigned DEAD = 3;
  localparam int unsigned LAT  = 2;
  localparam int unsigned GLAT = LAT + DEAD;

  localparam logic [3:0] E_NONE = 4'b0000;
  localparam logic [3:0] E_BUCK = 4'b1000;
  localparam logic [3:0] E_CHG  = 4'b0100;
  localparam logic [3:0] E_BST  = 4'b0010;
  localparam logic [3:0] E_FW   = 4'b0001;
  localparam logic [3:0] E_PAIR = 4'b1001;

  logic clk = 1'b0;
  logic rst_n;
  logic cyc, hm, hl;
  logic [2:0] flg; // 0 buck done, 1 peak, 2 boost done
  logic buck, chg, bst, fw;
  int   nvec = 0;
  int   nfail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  sido_path_seq #(.DEAD_CYC(DEAD)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cycle_i      (cyc),
    .buck_done_i  (flg[0]),
    .peak_i       (flg[1]),
    .boost_done_i (flg[2]),
    .hyst_mode_i  (hm),
    .hyst_low_i   (hl),
    .buck_en_o    (buck),
    .charge_en_o  (chg),
    .boost_en_o   (bst),
    .fw_en_o      (fw)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_en(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {buck, chg, bst, fw};
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: enables=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic expect_after(input logic [3:0] exp, input int lat, input string tag);
    if (lat > LAT) begin
      wait_n(lat - 1);
      check_en(E_NONE, {tag, " gap"});
      wait_n(1);
    end else begin
      wait_n(lat);
    end
    check_en(exp, tag);
  endtask

  task automatic strobe();
    cyc = 1'b0;
    wait_n(1);
    cyc = 1'b1;
  endtask

  function automatic logic [3:0] phase_en(input int ph);
    case (ph)
      0:       return E_BUCK;
      1:       return E_CHG;
      2:       return E_BST;
      default: return E_FW;
    endcase
  endfunction

  // R8 monitored on every sample
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic [3:0] e;
      e = {buck, chg, bst, fw};
      nvec++;
      if (!(e == E_NONE || $onehot(e) || e == E_PAIR)) begin
        nfail++;
        $display("FAIL R8: enables=%b expected at most one or %b", e, E_PAIR);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: R5 sequence stalled, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc = 1'b0; hm = 1'b0; hl = 1'b0; flg = 3'b000;
    wait_n(3);
    check_en(E_NONE, "R1 in reset");
    rst_n = 1'b1;
    wait_n(1);
    check_en(E_NONE, "R1 after reset");
    flg = 3'b111;
    wait_n(2);
    for (int f = 0; f < 3; f++) begin
      flg[f] = 1'b0;
      wait_n(3);
      check_en(E_NONE, "R1 idle flag fall");
      flg[f] = 1'b1;
      wait_n(1);
    end

    // first full cycle from idle
    strobe();
    expect_after(E_BUCK, LAT, "R2 start");
    flg[0] = 1'b0; expect_after(E_CHG, GLAT, "R3 charge"); flg[0] = 1'b1;
    flg[1] = 1'b0; expect_after(E_BST, GLAT, "R4 boost"); flg[1] = 1'b1;
    flg[2] = 1'b0; expect_after(E_FW,  GLAT, "R5 free");  flg[2] = 1'b1;
    wait_n(12);
    check_en(E_FW, "R5 held");

    // sweep: park in each phase, fire foreign flags, then restart
    for (int ph = 0; ph < 3; ph++) begin
      strobe();
      expect_after(E_BUCK, GLAT, "R2 new cycle");
      for (int k = 0; k < ph; k++) begin
        flg[k] = 1'b0;
        expect_after(phase_en(k + 1), GLAT, "R3 R4 advance");
        flg[k] = 1'b1;
      end
      for (int f = 0; f < 3; f++) begin
        if (f != ph) begin
          flg[f] = 1'b0;
          wait_n(GLAT + 1);
          check_en(phase_en(ph), "R6 foreign flag");
          flg[f] = 1'b1;
          wait_n(GLAT + 1);
          check_en(phase_en(ph), "R6 flag rise");
        end
      end
      strobe();
      if (ph == 0) begin
        wait_n(GLAT);
        check_en(E_BUCK, "R7 restart in buck");
      end else begin
        expect_after(E_BUCK, GLAT, "R7 restart");
      end
      flg[0] = 1'b0; expect_after(E_CHG, GLAT, "R3 charge"); flg[0] = 1'b1;
      flg[1] = 1'b0; expect_after(E_BST, GLAT, "R4 boost"); flg[1] = 1'b1;
      flg[2] = 1'b0; expect_after(E_FW,  GLAT, "R5 free");  flg[2] = 1'b1;
      wait_n(8);
      check_en(E_FW, "R5 held");
    end

    // hysteresis mode
    hm = 1'b1; hl = 1'b0;
    expect_after(E_NONE, LAT, "R10 enter");
    wait_n(DEAD + 3);
    hl = 1'b1;
    expect_after(E_PAIR, LAT, "R10 bypass on");
    flg = 3'b000;
    strobe();
    wait_n(GLAT + 2);
    check_en(E_PAIR, "R10 flags and strobe ignored");
    flg = 3'b111;
    hl = 1'b0;
    expect_after(E_NONE, LAT, "R10 bypass off");
    wait_n(DEAD + 3);
    check_en(E_NONE, "R10 stays off");
    hl = 1'b1;
    expect_after(E_PAIR, LAT, "R10 bypass again");
    wait_n(4);
    check_en(E_PAIR, "R10 bypass held");
    hm = 1'b0;
    expect_after(E_NONE, LAT, "R11 leave");
    wait_n(DEAD + 3);
    check_en(E_NONE, "R11 idle");
    strobe();
    expect_after(E_BUCK, LAT, "R11 restart");
    flg[0] = 1'b0;
    expect_after(E_CHG, GLAT, "R9 exact gap");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule